// File: doc/BRIEF.md
# Chained Block MAC Generator

This block computes a 64-bit authentication tag over a message presented as a stream of 64-bit blocks. A 64-bit running value starts at zero. Each accepted block is folded into that value by XOR, and the result then goes through a shortened Feistel cipher of sixteen rounds. Every round adds a 32-bit key word modulo 2^32 and passes the sum through eight loadable 4-bit substitution tables. It then rotates the result left by eleven places and XORs it into the other half. After the block flagged as last has gone through its rounds, the running value is presented as the tag.

Software loads the substitution tables one nibble at a time and holds the 256-bit key steady on a port. A clear strobe starts a new message. The block takes one data block at a time and drops its ready output while the rounds run. A message must contain at least two blocks. If the last flag arrives on the first block, the block reports an error instead of a tag.

Top module: `mac_imit_top`

## Requirements
- R1: After reset, blk_ready_o is 1, tag_valid_o is 0, err_o is 0 and tag_o is zero.
- R2: A table write with tbl_we_i high stores tbl_data_i as row tbl_addr_i[3:0] of table tbl_addr_i[6:4]. Table j translates bits 4j+3..4j of the round sum.
- R3: Key word j is key_i[32j+31:32j]. Rounds 1 to 8 use words 0 to 7 in rising order, and rounds 9 to 16 use words 0 to 7 in the same order again.
- R4: With A as the low 32 bits and B as the high 32 bits of the running value, every round produces A' = rotl11(S(A + K mod 2^32)) XOR B and B' = A. Round 16 uses the same swap as every other round.
- R5: Clear sets the running value to zero. Each accepted block is XORed into the running value, and the sixteen rounds are then applied to the result.
- R6: A block is accepted on a rising edge where blk_valid_i and blk_ready_o are both high. blk_ready_o is then low for exactly 16 cycles, and blocks offered in that time are not taken.
- R7: When the block carrying blk_last_i is the second or a later block, tag_valid_o rises at the same edge that ends its sixteenth round. tag_o then shows the running value with B in bits 63:32 and A in bits 31:0. Both hold, with blk_ready_o low, until clear. While tag_valid_o is low, tag_o reads zero.
- R8: A block offered with blk_last_i high as the first block after clear sets err_o at the next edge. No tag is produced, and blk_ready_o stays low until clear.
- R9: clr_i takes effect at the next edge and overrides everything else, including a round in progress and a block offered in the same cycle. It returns the block to its R1 output state with the running value at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_i | input | 256 | Eight 32-bit key words |
| tbl_we_i | input | 1 | Substitution table write enable |
| tbl_addr_i | input | 7 | Table index (6:4) and row (3:0) |
| tbl_data_i | input | 4 | Table row value |
| clr_i | input | 1 | Start a new message |
| blk_valid_i | input | 1 | Data block offered |
| blk_data_i | input | 64 | Data block |
| blk_last_i | input | 1 | Offered block ends the message |
| blk_ready_o | output | 1 | Block can be accepted |
| tag_valid_o | output | 1 | Tag available |
| tag_o | output | 64 | Authentication tag |
| err_o | output | 1 | Single-block message was rejected |

## Verification
The bench uses the default parameters: 32-bit halves, 4-bit nibbles, eight tables, eight key words and sixteen rounds. With these values the key reuse across rounds 9 to 16 and the 16-cycle busy window can be observed at the ports. With all table rows set to zero the substitution output vanishes, so sixteen plain swaps return the input unchanged. A two-block tag therefore equals the XOR of the two blocks, which checks the round-16 swap directly. A second table fill with non-trivial contents, applied to two-block and three-block messages, exercises the key order and the chaining against a behavioural model.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int WORD_W_D    = 32;
  localparam int NIB_W_D     = 4;
  localparam int N_BOX_D     = 8;
  localparam int KEY_WORDS_D = 8;
  localparam int ROUNDS_D    = 16;
  localparam int ROT_D       = 11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } mac_state_e;
endpackage

// File: rtl/mac_sbox_bank.sv
module mac_sbox_bank #(
  parameter int NIB_W = 4,
  parameter int N_BOX = 8,
  localparam int ROWS   = 1 << NIB_W,
  localparam int BOX_W  = $clog2(N_BOX),
  localparam int ADDR_W = BOX_W + NIB_W,
  localparam int VEC_W  = NIB_W * N_BOX
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  wdata_i,
  input  logic [VEC_W-1:0]  x_i,
  output logic [VEC_W-1:0]  y_o
);
  for (genvar b = 0; b < N_BOX; b++) begin : g_box
    logic [NIB_W-1:0] row_q [ROWS];
    logic             sel;

    assign sel = we_i && (addr_i[ADDR_W-1:NIB_W] == BOX_W'(b));

    always_ff @(posedge clk) begin
      if (sel) begin
        row_q[addr_i[NIB_W-1:0]] <= wdata_i;
      end
    end

    assign y_o[b*NIB_W +: NIB_W] = row_q[x_i[b*NIB_W +: NIB_W]];
  end
endmodule

// File: rtl/mac_round.sv
module mac_round #(
  parameter int WORD_W = 32,
  parameter int ROT    = 11
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] k_i,
  output logic [WORD_W-1:0] sum_o,
  input  logic [WORD_W-1:0] sub_i,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o
);
  logic [WORD_W-1:0] rot;

  always_comb begin
    sum_o = a_i + k_i;
    rot   = {sub_i[WORD_W-ROT-1:0], sub_i[WORD_W-1:WORD_W-ROT]};
    a_o   = rot ^ b_i;
    b_o   = a_i;
  end
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
#(
  parameter int ROUNDS = 16,
  localparam int RND_W = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             run_o,
  output logic [RND_W-1:0] rnd_o,
  output logic             tag_valid_o,
  output logic             err_o
);
  mac_state_e       st_q, st_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic             seen_q, seen_d;
  logic             last_q, last_d;
  logic             take, bad_first;

  always_comb begin
    take      = (st_q == ST_IDLE) && valid_i && !clr_i;
    bad_first = take && last_i && !seen_q;
    accept_o  = take && !bad_first;
    st_d      = st_q;
    rnd_d     = rnd_q;
    seen_d    = seen_q;
    last_d    = last_q;
    if (clr_i) begin
      st_d   = ST_IDLE;
      rnd_d  = '0;
      seen_d = 1'b0;
      last_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (bad_first) begin
            st_d = ST_FAULT;
          end else if (accept_o) begin
            st_d   = ST_RUN;
            rnd_d  = '0;
            seen_d = 1'b1;
            last_d = last_i;
          end
        end
        ST_RUN: begin
          rnd_d = rnd_q + 1'b1;
          if (rnd_q == RND_W'(ROUNDS - 1)) begin
            st_d = last_q ? ST_DONE : ST_IDLE;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rnd_q  <= '0;
      seen_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rnd_q  <= rnd_d;
      seen_q <= seen_d;
      last_q <= last_d;
    end
  end

  assign ready_o     = (st_q == ST_IDLE);
  assign run_o       = (st_q == ST_RUN) && !clr_i;
  assign rnd_o       = rnd_q;
  assign tag_valid_o = (st_q == ST_DONE);
  assign err_o       = (st_q == ST_FAULT);
endmodule

// File: rtl/mac_imit_top.sv
module mac_imit_top
  import mac_pkg::*;
#(
  parameter int WORD_W    = WORD_W_D,
  parameter int NIB_W     = NIB_W_D,
  parameter int KEY_WORDS = KEY_WORDS_D,
  parameter int ROUNDS    = ROUNDS_D,
  parameter int ROT       = ROT_D,
  localparam int BLK_W    = 2 * WORD_W,
  localparam int KEY_W    = KEY_WORDS * WORD_W,
  localparam int N_BOX    = WORD_W / NIB_W,
  localparam int ADDR_W   = $clog2(N_BOX) + NIB_W,
  localparam int RND_W    = $clog2(ROUNDS),
  localparam int KSEL_W   = $clog2(KEY_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              tbl_we_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [NIB_W-1:0]  tbl_data_i,
  input  logic              clr_i,
  input  logic              blk_valid_i,
  input  logic [BLK_W-1:0]  blk_data_i,
  input  logic              blk_last_i,
  output logic              blk_ready_o,
  output logic              tag_valid_o,
  output logic [BLK_W-1:0]  tag_o,
  output logic              err_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              accept, run;
  logic [RND_W-1:0]  rnd;
  logic [BLK_W-1:0]  st_q, st_d;
  logic [WORD_W-1:0] kw [KEY_WORDS];
  logic [WORD_W-1:0] k_cur, sum, sub, a_n, b_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar g = 0; g < KEY_WORDS; g++) begin : g_kw
    assign kw[g] = key_i[g*WORD_W +: WORD_W];
  end
  assign k_cur = kw[rnd[KSEL_W-1:0]];

  mac_ctrl #(.ROUNDS(ROUNDS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr_i      (clr_i),
    .valid_i    (blk_valid_i),
    .last_i     (blk_last_i),
    .ready_o    (blk_ready_o),
    .accept_o   (accept),
    .run_o      (run),
    .rnd_o      (rnd),
    .tag_valid_o(tag_valid_o),
    .err_o      (err_o)
  );

  mac_round #(.WORD_W(WORD_W), .ROT(ROT)) round_i (
    .a_i  (st_q[WORD_W-1:0]),
    .b_i  (st_q[BLK_W-1:WORD_W]),
    .k_i  (k_cur),
    .sum_o(sum),
    .sub_i(sub),
    .a_o  (a_n),
    .b_o  (b_n)
  );

  mac_sbox_bank #(.NIB_W(NIB_W), .N_BOX(N_BOX)) sbox_i (
    .clk    (clk),
    .we_i   (tbl_we_i),
    .addr_i (tbl_addr_i),
    .wdata_i(tbl_data_i),
    .x_i    (sum),
    .y_o    (sub)
  );

  always_comb begin
    st_d = st_q;
    if (clr_i)       st_d = '0;
    else if (accept) st_d = st_q ^ blk_data_i;
    else if (run)    st_d = {b_n, a_n};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= '0;
    else            st_q <= st_d;
  end

  assign tag_o = tag_valid_o ? st_q : '0;
endmodule

// File: rtl/mac_imit_chk.sv
module mac_imit_chk #(
  parameter int ROUNDS = 16,
  parameter int BLK_W  = 64,
  localparam int CNT_W = $clog2(ROUNDS) + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic             blk_valid_i,
  input logic             blk_ready_o,
  input logic             tag_valid_o,
  input logic [BLK_W-1:0] tag_o,
  input logic             err_o
);
  logic [CNT_W-1:0] busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          busy_q <= '0;
    else if (clr_i)                      busy_q <= '0;
    else if (blk_valid_i && blk_ready_o) busy_q <= '0;
    else if (!blk_ready_o)               busy_q <= busy_q + 1'b1;
  end

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (blk_ready_o && !tag_valid_o && !err_o)); // R9
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid_i && blk_ready_o && !clr_i) |=> !blk_ready_o); // R6
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(blk_ready_o) && !$past(clr_i)) |-> (busy_q == CNT_W'(ROUNDS))); // R6
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid_o && !clr_i) |=> (tag_valid_o && $stable(tag_o))); // R7
  AST_TAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid_o |-> (!blk_ready_o && !err_o)); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> (err_o && !blk_ready_o)); // R8
endmodule

bind mac_imit_top mac_imit_chk #(.ROUNDS(ROUNDS), .BLK_W(BLK_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .blk_valid_i(blk_valid_i),
  .blk_ready_o(blk_ready_o),
  .tag_valid_o(tag_valid_o),
  .tag_o      (tag_o),
  .err_o      (err_o)
);

// File: tb/mac_imit_top_tb.sv
module mac_imit_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] key_i;
  logic         tbl_we_i;
  logic [6:0]   tbl_addr_i;
  logic [3:0]   tbl_data_i;
  logic         clr_i;
  logic         blk_valid_i;
  logic [63:0]  blk_data_i;
  logic         blk_last_i;
  logic         blk_ready_o;
  logic         tag_valid_o;
  logic [63:0]  tag_o;
  logic         err_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [3:0] sb [8][16];

  // behavioural model state
  int          m_mode;   // 0 idle, 1 busy, 2 done, 3 fault
  int          m_cnt;
  bit          m_seen, m_last;
  logic [63:0] m_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_imit_top dut_i (
    .clk(clk), .rst_n(rst_n), .key_i(key_i),
    .tbl_we_i(tbl_we_i), .tbl_addr_i(tbl_addr_i), .tbl_data_i(tbl_data_i),
    .clr_i(clr_i), .blk_valid_i(blk_valid_i), .blk_data_i(blk_data_i),
    .blk_last_i(blk_last_i), .blk_ready_o(blk_ready_o),
    .tag_valid_o(tag_valid_o), .tag_o(tag_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mix16(input logic [63:0] v);
    logic [31:0] a, b, s, t, n;
    a = v[31:0];
    b = v[63:32];
    for (int r = 0; r < 16; r++) begin
      s = a + key_i[(r % 8)*32 +: 32];
      for (int j = 0; j < 8; j++) t[j*4 +: 4] = sb[j][s[j*4 +: 4]];
      n = ((t << 11) | (t >> 21)) ^ b;
      b = a;
      a = n;
    end
    return {b, a};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_seen = 0; m_last = 0; m_val = '0;
    end else if (clr_i) begin
      m_mode = 0; m_cnt = 0; m_seen = 0; m_last = 0; m_val = '0;
    end else begin
      case (m_mode)
        0: if (blk_valid_i) begin
          if (blk_last_i && !m_seen) m_mode = 3;
          else begin
            m_val = mix16(m_val ^ blk_data_i);
            m_seen = 1; m_last = blk_last_i; m_cnt = 16; m_mode = 1;
          end
        end
        1: begin
          m_cnt--;
          if (m_cnt == 0) m_mode = m_last ? 2 : 0;
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(blk_ready_o == (m_mode == 0), "R6 ready", 64'(blk_ready_o), 64'(m_mode == 0));
      chk(tag_valid_o == (m_mode == 2), "R7 tag_valid", 64'(tag_valid_o), 64'(m_mode == 2));
      chk(err_o == (m_mode == 3), "R8 err", 64'(err_o), 64'(m_mode == 3));
      chk(tag_o == ((m_mode == 2) ? m_val : 64'h0), "R7 tag", tag_o, (m_mode == 2) ? m_val : 64'h0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WDOG_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic load_tables(input bit zero);
    for (int b = 0; b < 8; b++) begin
      for (int r = 0; r < 16; r++) begin
        @(negedge clk);
        sb[b][r]   = zero ? 4'h0 : 4'((r * (2*b + 3) + b*5 + 1) & 15);
        tbl_we_i   = 1'b1;
        tbl_addr_i = {3'(b), 4'(r)};
        tbl_data_i = sb[b][r];
      end
    end
    @(negedge clk);
    tbl_we_i = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic send(input logic [63:0] d, input bit last);
    @(negedge clk);
    blk_valid_i = 1'b1;
    blk_data_i  = d;
    blk_last_i  = last;
    while (!blk_ready_o) @(negedge clk);
    @(negedge clk);
    blk_valid_i = 1'b0;
    blk_last_i  = 1'b0;
  endtask

  task automatic wait_tag();
    for (int i = 0; i < 40 && !tag_valid_o; i++) @(negedge clk);
  endtask

  initial begin
    logic [63:0] exp;
    rst_n = 1'b0; clr_i = 0; tbl_we_i = 0; tbl_addr_i = '0; tbl_data_i = '0;
    blk_valid_i = 0; blk_data_i = '0; blk_last_i = 0;
    for (int i = 0; i < 8; i++) key_i[i*32 +: 32] = 32'h1357_9BDF * (i + 1) + 32'h0F0F_1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(blk_ready_o && !tag_valid_o && !err_o && tag_o == 0, "R1 reset outputs",
        {tag_o[60:0], blk_ready_o, tag_valid_o, err_o}, 64'h4);

    // R4 R5: zero tables -> sixteen swaps are identity, tag = d1 ^ d2
    load_tables(1'b1);
    pulse_clr();
    send(64'hDEAD_BEEF_0123_4567, 1'b0);
    send(64'h0F1E_2D3C_4B5A_6978, 1'b1);
    wait_tag();
    chk(tag_o == (64'hDEAD_BEEF_0123_4567 ^ 64'h0F1E_2D3C_4B5A_6978),
        "R4 R5 zero-table identity", tag_o, 64'hDEAD_BEEF_0123_4567 ^ 64'h0F1E_2D3C_4B5A_6978);

    // R2 R3 R4: loaded tables, two blocks, valid held while busy
    load_tables(1'b0);
    pulse_clr();
    exp = mix16(mix16(64'h0000_0001_8000_0000) ^ 64'hFFFF_FFFF_FFFF_FFFF);
    send(64'h0000_0001_8000_0000, 1'b0);
    send(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    wait_tag();
    chk(tag_valid_o && tag_o == exp, "R2 R3 two-block tag", tag_o, exp);

    // R5: three-block chaining
    pulse_clr();
    exp = mix16(mix16(mix16(64'h1111_2222_3333_4444) ^ 64'h5555_6666_7777_8888) ^ 64'h0);
    send(64'h1111_2222_3333_4444, 1'b0);
    send(64'h5555_6666_7777_8888, 1'b0);
    send(64'h0, 1'b1);
    wait_tag();
    chk(tag_valid_o && tag_o == exp, "R5 three-block tag", tag_o, exp);

    // R9 clear drops tag
    pulse_clr();
    chk(blk_ready_o && !tag_valid_o && tag_o == 0, "R9 clear after tag", tag_o, 64'h0);

    // R8 single-block message
    send(64'hA5A5_A5A5_5A5A_5A5A, 1'b1);
    chk(err_o && !tag_valid_o, "R8 error flag", 64'(err_o), 64'h1);
    repeat (20) @(negedge clk);
    chk(!blk_ready_o && err_o && !tag_valid_o, "R8 stays stalled", 64'(blk_ready_o), 64'h0);
    pulse_clr();
    chk(!err_o && blk_ready_o, "R9 clear after error", 64'(err_o), 64'h0);

    // R9 clear mid-run, then a fresh message starts from zero
    send(64'hCAFE_F00D_CAFE_F00D, 1'b0);
    repeat (5) @(negedge clk);
    clr_i = 1'b1; blk_valid_i = 1'b1; blk_data_i = 64'h77; blk_last_i = 1'b0;
    @(negedge clk);
    clr_i = 1'b0; blk_valid_i = 1'b0;
    chk(blk_ready_o && !err_o && !tag_valid_o, "R9 clear mid-run", 64'(blk_ready_o), 64'h1);
    exp = mix16(mix16(64'h2468_ACE0_1357_9BDF) ^ 64'h8642_0ECA_FDB9_7531);
    send(64'h2468_ACE0_1357_9BDF, 1'b0);
    send(64'h8642_0ECA_FDB9_7531, 1'b1);
    wait_tag();
    chk(tag_valid_o && tag_o == exp, "R9 fresh message after clear", tag_o, exp);
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule